// File: doc/BRIEF.md
# Byte-Wide Host Mailbox Controller (Keyboard Controller Style)

This block is the management-controller side of a Keyboard Controller Style system interface. The host sees two byte registers: offset 0 carries data in both directions, and offset 1 takes control codes on writes and returns a status byte on reads. A protocol state machine collects the host's request bytes into an input buffer. It hands the finished request to a backend with a one-cycle valid pulse, a length and a sequence tag. It then takes the backend's response into an output buffer and returns it to the host one byte per read code.

Flow control uses two flags. The input-full flag blocks further host writes. The output-full flag tells the host that a byte waits at offset 0. Protocol misuse drives the interface into an error state, from which the host can fetch a one-byte status code. A level interrupt follows two separately tracked sources, the output-full flag and an attention request from the backend. An enable input gates only the raising of the line.

Top module: `kcs_host_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, the interrupt is low and req_valid is low.
- R2: A read at offset 0 returns the data-out byte and clears the output-full flag. A read at offset 1 returns the status byte: bits 7:6 state (0 idle, 1 read, 2 write, 3 error), bit 3 last write was a control code, bit 2 attention, bit 1 input full, bit 0 output full. A read at any other offset returns 0xFF, and a write to any other offset has no effect.
- R3: While input-full is set, every host write is ignored, including the control-code bit. Otherwise a data write clears bit 3 and a control-code write sets it.
- R4: In idle, code 0x61 enters the write state and sets output-full. In the write state each data byte, and the code 0x62, sets output-full.
- R5: The first data byte after 0x62 ends the message. In the cycle after that byte, req_valid is high for one cycle with req_len equal to the total byte count and req_tag equal to the expected tag. Input-full stays set. The buffer holds the first DEPTH bytes and drops any further bytes, although they still count toward the length.
- R6: A response completion whose tag equals the expected tag increments the tag, clears input-full, enters the read state, and places byte 0 at offset 0 with output-full set. A completion or byte write with any other tag is ignored.
- R7: A response longer than DEPTH is returned as its first two bytes followed by 0xCA.
- R8: In the read state, data value 0x68 loads the next byte and sets output-full. When no bytes remain it returns to idle and sets output-full without a new byte.
- R9: In the read state any data value other than 0x68 enters the error state with status 0x02 and sets output-full. Any control code other than 0x60 enters the error state with status 0x02: with output-full set in the read and write states (0x62 excepted in the write state), and without it in idle and error.
- R10: Code 0x60 in any state but error enters the error state with status 0x01, sets output-full and advances the expected tag. In the error state it has no effect.
- R11: In the error state a data write enters the read state with the status byte at offset 0. A following 0x68 returns the block to idle.
- R12: The interrupt rises when the output-full source or the attention source becomes set while the other is clear and the enable input is high. It falls only when both sources are clear. A data read clears the output-full source and a status read clears the attention source.
- R13: An attention write copies atn_val into status bit 2. The attention source is set only when atn_val and atn_irq_req are both high, and is cleared by atn_val low.
- R14: A matching response of length zero goes straight to idle with output-full set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (side effects on the clock edge) |
| host_addr | input | ADDR_W | Host register offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (combinational from offset) |
| irq_en | input | 1 | Allows the interrupt line to rise |
| irq | output | 1 | Level interrupt |
| atn_wr | input | 1 | Backend attention update strobe |
| atn_val | input | 1 | New attention bit value |
| atn_irq_req | input | 1 | Attention update also requests an interrupt |
| req_valid | output | 1 | One-cycle pulse: a request message is complete |
| req_len | output | LEN_W | Byte count of the request, including dropped bytes |
| req_tag | output | TAG_W | Tag the response must carry |
| req_rd_idx | input | IDX_W | Backend read index into the request buffer |
| req_rd_data | output | 8 | Request byte at req_rd_idx |
| rsp_wr | input | 1 | Backend writes one response byte |
| rsp_idx | input | IDX_W | Response byte index |
| rsp_byte | input | 8 | Response byte value |
| rsp_done | input | 1 | Response completion strobe |
| rsp_len | input | LEN_W | Response length in bytes |
| rsp_tag | input | TAG_W | Tag of the response byte or completion |

## Verification
The bench builds the block with DEPTH 4, LEN_W 8 and TAG_W 4. At these values the buffer boundary sits within a few bytes. A sweep over every request length from 1 to 6 and every response length from 0 to 6 therefore covers the dropped-byte length count, the exact-fit response, the truncation to two bytes plus 0xCA, and the zero-length response. The small tag width makes the tag wrap during the sweep. Directed sequences add the abort, illegal-code and error-readout paths, and the interrupt source and enable interplay.

// File: rtl/kcs_pkg.sv
package kcs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_ERROR = 2'd3
  } kcs_state_e;

  localparam logic [7:0] CODE_ABORT  = 8'h60;
  localparam logic [7:0] CODE_WSTART = 8'h61;
  localparam logic [7:0] CODE_WEND   = 8'h62;
  localparam logic [7:0] CODE_RNEXT  = 8'h68;

  localparam logic [7:0] STS_ABORTED = 8'h01;
  localparam logic [7:0] STS_ILLEGAL = 8'h02;
  localparam logic [7:0] CC_TRUNC    = 8'hCA;
  localparam logic [7:0] RD_UNMAPPED = 8'hFF;
endpackage

// File: rtl/kcs_byte_ram.sv
module kcs_byte_ram #(
  parameter int DEPTH = 300,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (32'(waddr) < DEPTH)) mem[waddr] <= wdata;
  end

  always_comb begin
    if (32'(raddr) < DEPTH) rdata = mem[raddr];
    else                    rdata = 8'h00;
  end
endmodule

// File: rtl/kcs_irq_ctrl.sv
module kcs_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_en,
  input  logic obf_set,
  input  logic obf_clr,
  input  logic atn_set,
  input  logic atn_clr,
  output logic obf_src,
  output logic atn_src,
  output logic irq
);
  logic obf_q, obf_n, atn_q, atn_n, line_q, line_n, raise;

  always_comb begin
    obf_n = obf_q;
    if (obf_clr) obf_n = 1'b0;
    if (obf_set) obf_n = 1'b1;
    atn_n = atn_q;
    if (atn_clr) atn_n = 1'b0;
    if (atn_set) atn_n = 1'b1;
    raise  = (obf_set | atn_set) & ~obf_q & ~atn_q;
    line_n = line_q;
    if (raise && irq_en) line_n = 1'b1;
    if (!obf_n && !atn_n) line_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obf_q  <= 1'b0;
      atn_q  <= 1'b0;
      line_q <= 1'b0;
    end else begin
      obf_q  <= obf_n;
      atn_q  <= atn_n;
      line_q <= line_n;
    end
  end

  assign obf_src = obf_q;
  assign atn_src = atn_q;
  assign irq     = line_q;
endmodule

// File: rtl/kcs_host_ctrl.sv
module kcs_host_ctrl
  import kcs_pkg::*;
#(
  parameter  int DEPTH  = 300,
  parameter  int LEN_W  = 16,
  parameter  int TAG_W  = 8,
  parameter  int ADDR_W = 2,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              irq_en,
  output logic              irq,
  input  logic              atn_wr,
  input  logic              atn_val,
  input  logic              atn_irq_req,
  output logic              req_valid,
  output logic [LEN_W-1:0]  req_len,
  output logic [TAG_W-1:0]  req_tag,
  input  logic [IDX_W-1:0]  req_rd_idx,
  output logic [7:0]        req_rd_data,
  input  logic              rsp_wr,
  input  logic [IDX_W-1:0]  rsp_idx,
  input  logic [7:0]        rsp_byte,
  input  logic              rsp_done,
  input  logic [LEN_W-1:0]  rsp_len,
  input  logic [TAG_W-1:0]  rsp_tag
);
  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int = rst_pipe[1];

  kcs_state_e       state_q, state_n;
  logic             obf_q, obf_n, ibf_q, ibf_n, cd_q, cd_n, sms_q, sms_n;
  logic             wend_q, wend_n;
  logic [7:0]       dout_q, dout_n;
  logic [LEN_W-1:0] inlen_q, inlen_n, outlen_q, outlen_n, outpos_q, outpos_n;
  logic [TAG_W-1:0] tag_q, tag_n;
  logic             req_valid_q;
  logic [LEN_W-1:0] req_len_q;
  logic [TAG_W-1:0] req_tag_q;

  logic             rsp_hit, wr_ok, is_data, is_cmd, rd_data, rd_stat;
  logic             req_fire, set_obf, err_go, trunc_we, step, in_we;
  logic [7:0]       err_code, step_code;
  logic [LEN_W-1:0] step_len, step_pos;
  logic             out_we;
  logic [IDX_W-1:0] out_waddr;
  logic [7:0]       out_wdata, out_rdata;
  logic             obf_src_w, atn_src_w;

  assign rsp_hit = rsp_done & (rsp_tag == tag_q);
  assign wr_ok   = host_wr & ~ibf_q & ~rsp_hit;
  assign is_data = wr_ok & (host_addr == ADDR_W'(0));
  assign is_cmd  = wr_ok & (host_addr == ADDR_W'(1));
  assign rd_data = host_rd & (host_addr == ADDR_W'(0));
  assign rd_stat = host_rd & (host_addr == ADDR_W'(1));

  // Protocol next-state logic
  always_comb begin
    state_n   = state_q;
    obf_n     = obf_q;
    ibf_n     = ibf_q;
    cd_n      = cd_q;
    sms_n     = sms_q;
    wend_n    = wend_q;
    dout_n    = dout_q;
    inlen_n   = inlen_q;
    outlen_n  = outlen_q;
    outpos_n  = outpos_q;
    tag_n     = tag_q;
    req_fire  = 1'b0;
    set_obf   = 1'b0;
    err_go    = 1'b0;
    err_code  = STS_ILLEGAL;
    trunc_we  = 1'b0;
    in_we     = 1'b0;
    step      = 1'b0;
    step_code = host_wdata;
    step_len  = outlen_q;
    step_pos  = outpos_q;

    if (rsp_hit) begin
      tag_n   = tag_q + 1'b1;
      ibf_n   = 1'b0;
      state_n = ST_READ;
      if (rsp_len > LEN_W'(DEPTH)) begin
        outlen_n = LEN_W'(3);
        trunc_we = 1'b1;
      end else begin
        outlen_n = rsp_len;
      end
      step      = 1'b1;
      step_code = CODE_RNEXT;
      step_len  = outlen_n;
      step_pos  = '0;
    end else if (is_cmd) begin
      cd_n = 1'b1;
      if (host_wdata == CODE_ABORT) begin
        if (state_q != ST_ERROR) begin
          tag_n    = tag_q + 1'b1;
          err_go   = 1'b1;
          err_code = STS_ABORTED;
          set_obf  = 1'b1;
        end
      end else begin
        case (state_q)
          ST_IDLE: begin
            if (host_wdata == CODE_WSTART) begin
              state_n = ST_WRITE;
              wend_n  = 1'b0;
              inlen_n = '0;
              set_obf = 1'b1;
            end else begin
              err_go = 1'b1;
            end
          end
          ST_WRITE: begin
            set_obf = 1'b1;
            if (host_wdata == CODE_WEND) wend_n = 1'b1;
            else                         err_go = 1'b1;
          end
          ST_READ: begin
            set_obf = 1'b1;
            err_go  = 1'b1;
          end
          default: err_go = 1'b1;
        endcase
      end
    end else if (is_data) begin
      cd_n = 1'b0;
      case (state_q)
        ST_READ: step = 1'b1;
        ST_ERROR: begin
          state_n   = ST_READ;
          step      = 1'b1;
          step_code = CODE_RNEXT;
        end
        ST_WRITE: begin
          in_we   = (inlen_q < LEN_W'(DEPTH));
          inlen_n = inlen_q + 1'b1;
          if (wend_q) begin
            req_fire = 1'b1;
            wend_n   = 1'b0;
            outlen_n = '0;
            outpos_n = '0;
            ibf_n    = 1'b1;
          end else begin
            set_obf = 1'b1;
          end
        end
        default: ;
      endcase
    end

    if (step) begin
      if (step_pos >= step_len) begin
        state_n = ST_IDLE;
        set_obf = 1'b1;
      end else if (step_code == CODE_RNEXT) begin
        dout_n   = out_rdata;
        outpos_n = step_pos + 1'b1;
        set_obf  = 1'b1;
      end else begin
        err_go  = 1'b1;
        set_obf = 1'b1;
      end
    end

    if (err_go) begin
      state_n  = ST_ERROR;
      outlen_n = LEN_W'(1);
      outpos_n = '0;
    end

    if (atn_wr)  sms_n = atn_val;
    if (rd_data) obf_n = 1'b0;
    if (set_obf) obf_n = 1'b1;
  end

  // Output buffer write port: protocol writes take priority over the backend
  always_comb begin
    out_we    = 1'b0;
    out_waddr = '0;
    out_wdata = 8'h00;
    if (err_go) begin
      out_we    = 1'b1;
      out_wdata = err_code;
    end else if (trunc_we) begin
      out_we    = 1'b1;
      out_waddr = IDX_W'(2);
      out_wdata = CC_TRUNC;
    end else if (rsp_wr && (rsp_tag == tag_q)) begin
      out_we    = 1'b1;
      out_waddr = rsp_idx;
      out_wdata = rsp_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      state_q     <= ST_IDLE;
      obf_q       <= 1'b0;
      ibf_q       <= 1'b0;
      cd_q        <= 1'b0;
      sms_q       <= 1'b0;
      wend_q      <= 1'b0;
      dout_q      <= 8'h00;
      inlen_q     <= '0;
      outlen_q    <= '0;
      outpos_q    <= '0;
      tag_q       <= '0;
      req_valid_q <= 1'b0;
      req_len_q   <= '0;
      req_tag_q   <= '0;
    end else begin
      state_q     <= state_n;
      obf_q       <= obf_n;
      ibf_q       <= ibf_n;
      cd_q        <= cd_n;
      sms_q       <= sms_n;
      wend_q      <= wend_n;
      dout_q      <= dout_n;
      inlen_q     <= inlen_n;
      outlen_q    <= outlen_n;
      outpos_q    <= outpos_n;
      tag_q       <= tag_n;
      req_valid_q <= req_fire;
      if (req_fire) begin
        req_len_q <= inlen_n;
        req_tag_q <= tag_q;
      end
    end
  end

  kcs_byte_ram #(.DEPTH(DEPTH), .AW(IDX_W)) u_inbuf (
    .clk   (clk),
    .we    (in_we),
    .waddr (inlen_q[IDX_W-1:0]),
    .wdata (host_wdata),
    .raddr (req_rd_idx),
    .rdata (req_rd_data)
  );

  kcs_byte_ram #(.DEPTH(DEPTH), .AW(IDX_W)) u_outbuf (
    .clk   (clk),
    .we    (out_we),
    .waddr (out_waddr),
    .wdata (out_wdata),
    .raddr (step_pos[IDX_W-1:0]),
    .rdata (out_rdata)
  );

  kcs_irq_ctrl u_irq (
    .clk     (clk),
    .rst_n   (rst_int),
    .irq_en  (irq_en),
    .obf_set (set_obf),
    .obf_clr (rd_data),
    .atn_set (atn_wr & atn_val & atn_irq_req),
    .atn_clr ((atn_wr & ~atn_val) | rd_stat),
    .obf_src (obf_src_w),
    .atn_src (atn_src_w),
    .irq     (irq)
  );

  always_comb begin
    if (host_addr == ADDR_W'(0))      host_rdata = dout_q;
    else if (host_addr == ADDR_W'(1)) host_rdata = {state_q, 2'b00, cd_q, sms_q, ibf_q, obf_q};
    else                              host_rdata = RD_UNMAPPED;
  end

  assign req_valid = req_valid_q;
  assign req_len   = req_len_q;
  assign req_tag   = req_tag_q;
endmodule

// File: rtl/kcs_host_chk.sv
module kcs_host_chk #(
  parameter int LEN_W  = 16,
  parameter int TAG_W  = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic [ADDR_W-1:0] host_addr,
  input logic [7:0]        host_wdata,
  input logic              rsp_done,
  input logic [TAG_W-1:0]  rsp_tag,
  input logic              irq,
  input logic              irq_en,
  input logic              req_valid,
  input logic [1:0]        state,
  input logic              ibf,
  input logic              obf,
  input logic [LEN_W-1:0]  outpos,
  input logic [LEN_W-1:0]  outlen,
  input logic [TAG_W-1:0]  tag,
  input logic              src_obf,
  input logic              src_atn
);
  logic rsp_match;
  assign rsp_match = rsp_done && (rsp_tag == tag);

  // R5
  ibf_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ibf) |-> req_valid);

  // R3
  wr_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ibf && host_wr && !rsp_done) |=> (ibf && state == $past(state)));

  // R10
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == ADDR_W'(1) && host_wdata == 8'h60 && !ibf &&
     state != 2'd3 && !rsp_match)
    |=> (state == 2'd3 && obf && tag == TAG_W'($past(tag) + 1'b1)));

  // R9
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == ADDR_W'(0) && host_wdata != 8'h68 && !ibf &&
     state == 2'd1 && outpos < outlen && !rsp_match)
    |=> (state == 2'd3 && obf));

  // R8
  read_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd1) |-> (outpos <= outlen));

  // R12
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (src_obf || src_atn));

  // R12
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(irq_en));
endmodule

bind kcs_host_ctrl kcs_host_chk #(.LEN_W(LEN_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_int),
  .host_wr    (host_wr),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .rsp_done   (rsp_done),
  .rsp_tag    (rsp_tag),
  .irq        (irq),
  .irq_en     (irq_en),
  .req_valid  (req_valid),
  .state      (state_q),
  .ibf        (ibf_q),
  .obf        (obf_q),
  .outpos     (outpos_q),
  .outlen     (outlen_q),
  .tag        (tag_q),
  .src_obf    (obf_src_w),
  .src_atn    (atn_src_w)
);

// File: tb/sim_kcs_host_ctrl.sv
module sim_kcs_host_ctrl;
  localparam int DEPTH = 4;
  localparam int LEN_W = 8;
  localparam int TAG_W = 4;
  localparam int IW    = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic host_wr, host_rd, irq_en, irq, atn_wr, atn_val, atn_irq_req;
  logic [1:0] host_addr;
  logic [7:0] host_wdata, host_rdata, req_rd_data, rsp_byte;
  logic req_valid, rsp_wr, rsp_done;
  logic [LEN_W-1:0] req_len, rsp_len;
  logic [TAG_W-1:0] req_tag, rsp_tag, et;
  logic [IW-1:0] req_rd_idx, rsp_idx;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  kcs_host_ctrl #(.DEPTH(DEPTH), .LEN_W(LEN_W), .TAG_W(TAG_W)) u0 (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq_en(irq_en), .irq(irq), .atn_wr(atn_wr), .atn_val(atn_val),
    .atn_irq_req(atn_irq_req), .req_valid(req_valid), .req_len(req_len),
    .req_tag(req_tag), .req_rd_idx(req_rd_idx), .req_rd_data(req_rd_data),
    .rsp_wr(rsp_wr), .rsp_idx(rsp_idx), .rsp_byte(rsp_byte),
    .rsp_done(rsp_done), .rsp_len(rsp_len), .rsp_tag(rsp_tag)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw(input int a, input int d);
    @(negedge clk);
    host_addr = 2'(a); host_wdata = 8'(d); host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hr(input int a, output logic [7:0] v);
    @(negedge clk);
    host_addr = 2'(a); host_rd = 1'b1;
    #1 v = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  function automatic logic [7:0] req_b(input int n, input int i);
    return 8'(16 * n + i);
  endfunction

  function automatic logic [7:0] rsp_b(input int n, input int i);
    return 8'(8'h80 + 8 * n + i);
  endfunction

  // Host sends an n-byte message; checks R4, R5 and the blocked writes of R3.
  task automatic send_msg(input int n);
    logic [7:0] v;
    hw(1, 8'h61); hr(1, v); chk("R4 write-start status", v, 8'h89); hr(0, v);
    for (int i = 0; i < n - 1; i++) begin
      hw(0, req_b(n, i)); hr(1, v); chk("R4 data byte status", v, 8'h81); hr(0, v);
    end
    hw(1, 8'h62); hr(1, v); chk("R4 write-end status", v, 8'h89); hr(0, v);
    hw(0, req_b(n, n - 1));
    chk("R5 req_valid pulse", req_valid, 1);
    chk("R5 req_len", req_len, n);
    chk("R5 req_tag", req_tag, et);
    @(negedge clk);
    chk("R5 req_valid one cycle", req_valid, 0);
    hr(1, v); chk("R5 input-full held", v, 8'h82);
    for (int i = 0; i < n && i < DEPTH; i++) begin
      req_rd_idx = IW'(i);
      #1 chk("R5 request buffer byte", req_rd_data, req_b(n, i));
    end
    hw(1, 8'h60); hr(1, v); chk("R3 write ignored while input full", v, 8'h82);
  endtask

  task automatic respond(input int n, input int m, input logic [TAG_W-1:0] tg);
    for (int i = 0; i < m && i < DEPTH; i++) begin
      @(negedge clk);
      rsp_wr = 1'b1; rsp_idx = IW'(i); rsp_byte = rsp_b(n, i); rsp_tag = tg;
      @(negedge clk);
      rsp_wr = 1'b0;
    end
    @(negedge clk);
    rsp_done = 1'b1; rsp_len = LEN_W'(m); rsp_tag = tg;
    @(negedge clk);
    rsp_done = 1'b0;
  endtask

  // Host reads back an m-byte response; R6, R7, R8, R14.
  task automatic drain(input int n, input int m);
    logic [7:0] v, e;
    int len;
    len = (m > DEPTH) ? 3 : m;
    hr(1, v);
    if (len == 0) begin
      chk("R14 empty response idle", v, 8'h01);
      hr(0, v);
      return;
    end
    chk("R6 response enters read", v, 8'h41);
    for (int k = 0; k < len; k++) begin
      e = (m > DEPTH && k == 2) ? 8'hCA : rsp_b(n, k);
      hr(0, v);
      if (m > DEPTH) chk("R7 truncated response byte", v, e);
      else           chk("R8 response byte", v, e);
      hw(0, 8'h68);
      hr(1, v);
      chk("R8 status after read code", v, (k < len - 1) ? 8'h41 : 8'h01);
    end
    hr(0, v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; host_wr = 0; host_rd = 0; host_addr = 0; host_wdata = 0;
    irq_en = 0; atn_wr = 0; atn_val = 0; atn_irq_req = 0; req_rd_idx = 0;
    rsp_wr = 0; rsp_idx = 0; rsp_byte = 0; rsp_done = 0; rsp_len = 0; rsp_tag = 0;
    et = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 / R2 reset and decode
    hr(1, v); chk("R1 reset status", v, 8'h00);
    chk("R1 reset irq", irq, 0);
    chk("R1 reset req_valid", req_valid, 0);
    hr(2, v); chk("R2 unmapped read", v, 8'hFF);
    hr(3, v); chk("R2 unmapped read offset 3", v, 8'hFF);
    hw(2, 8'h61); hr(1, v); chk("R2 unmapped write no effect", v, 8'h00);

    // R10 abort from idle, then abort in error
    hw(1, 8'h60); et = et + 1'b1;
    hr(1, v); chk("R10 abort status", v, 8'hC9); hr(0, v);
    hw(1, 8'h60); hr(1, v); chk("R10 abort in error no effect", v, 8'hC8);
    hw(0, 8'h00); hr(1, v); chk("R11 error data to read", v, 8'h41);
    hr(0, v); chk("R10 aborted status byte", v, 8'h01);
    hw(0, 8'h68); hr(1, v); chk("R11 back to idle", v, 8'h01); hr(0, v);

    // R9 illegal code in idle: error without output-full
    hw(1, 8'h55); hr(1, v); chk("R9 illegal code in idle", v, 8'hC8);
    hw(0, 8'h33); hr(0, v); chk("R9 illegal status byte", v, 8'h02);
    hw(0, 8'h68); hr(0, v);

    // R9 unexpected code in write state: error with output-full
    hw(1, 8'h61); hr(0, v);
    hw(1, 8'h61); hr(1, v); chk("R9 code in write state", v, 8'hC9);
    hw(0, 8'h00); hr(0, v); chk("R9 status after write-state code", v, 8'h02);
    hw(0, 8'h68); hr(0, v);

    // R9 wrong data in read state; R6 stale tag ignored
    send_msg(1);
    respond(1, 2, et + 1'b1);
    hr(1, v); chk("R6 stale tag ignored", v, 8'h82);
    respond(1, 2, et); et = et + 1'b1;
    hr(1, v); chk("R6 matching tag", v, 8'h41);
    hr(0, v); chk("R6 first byte preloaded", v, rsp_b(1, 0));
    hw(0, 8'h00); hr(1, v); chk("R9 wrong read code", v, 8'hC1);
    hw(0, 8'h00); hr(0, v); chk("R9 wrong read code status byte", v, 8'h02);
    hw(0, 8'h68); hr(0, v);

    // R12 / R13 interrupt sources
    irq_en = 1'b1;
    hw(1, 8'h61); chk("R12 irq on output-full", irq, 1);
    hr(0, v); chk("R12 irq falls on data read", irq, 0);
    @(negedge clk); atn_wr = 1; atn_val = 1; atn_irq_req = 1;
    @(negedge clk); atn_wr = 0;
    chk("R13 irq on attention", irq, 1);
    hw(0, 8'h07); hr(0, v); chk("R12 irq held by attention", irq, 1);
    hr(1, v); chk("R13 attention bit", v, 8'h84);
    chk("R12 irq falls on status read", irq, 0);
    @(negedge clk); atn_wr = 1; atn_val = 0;
    @(negedge clk); atn_wr = 0;
    hr(1, v); chk("R13 attention cleared", v, 8'h80);
    irq_en = 1'b0;
    hw(0, 8'h08); chk("R12 enable gates raising", irq, 0); hr(0, v);
    @(negedge clk); atn_wr = 1; atn_val = 1; atn_irq_req = 0;
    @(negedge clk); atn_wr = 0;
    hr(1, v); chk("R13 attention without irq request", v, 8'h84);
    chk("R13 no irq without request", irq, 0);
    @(negedge clk); atn_wr = 1; atn_val = 0;
    @(negedge clk); atn_wr = 0;
    hw(1, 8'h60); et = et + 1'b1; hr(0, v);
    hw(0, 8'h00); hr(0, v); chk("R10 abort from write state", v, 8'h01);
    hw(0, 8'h68); hr(0, v);

    // Sweep of request and response lengths around the buffer depth
    for (int n = 1; n <= 6; n++) begin
      for (int m = 0; m <= 6; m++) begin
        send_msg(n);
        respond(n, m, et);
        et = et + 1'b1;
        drain(n, m);
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule